// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

The block stores a four-bit binary-coded decimal digit and turns the stored value into the seven signals of a segment display. A load enable decides when the stored digit is refreshed. While it is high, the register takes the input digit on every rising clock edge. While it is low, the register keeps its value. The stored digit is decoded into segments a to g. Codes above nine give a dark display and never a hex glyph.

Two controls act on the decoded pattern only. A blanking input turns every segment off. A phase input inverts all seven outputs. With phase tied to a backplane square wave, the block drives an AC-driven LCD, and each lit segment runs out of phase with the backplane. With phase tied high, the block drives active-low LED segment buffers. An on-block divider produces a 50% duty square wave for the backplane. A build parameter chooses this wave instead of the phase pin as the phase source.

Top module: `bcd_seg_latch_dec`

## Requirements
- R1: When load_en_i is high at a rising clock edge, the stored digit takes digit_i, and seg_o shows it right after that edge. A change of digit_i before the edge does not alter seg_o.
- R2: When load_en_i is low, no change of digit_i alters the stored digit or seg_o, for any number of cycles.
- R3: When blank_i is high, all seven segments are at the off level. The off level is all zeros with phase low and all ones with phase high, whatever digit is stored.
- R4: seg_o bit 0 is segment a and bit 6 is segment g. With phase low, the digits give: 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D, 7=7'h07, 8=7'h7F, 9=7'h6F.
- R5: Stored codes 10 to 15 give a dark display, with every segment at the off level.
- R6: With phase high, seg_o is the bitwise inverse of the phase-low result, and this includes the blanked case.
- R7: Blanking and phase do not touch the stored digit. When blank_i falls, the held digit reappears without a reload.
- R8: rst_ni low clears the stored digit to 0, and the backplane output goes low.
- R9: bp_o toggles on every DIV_HALF-th rising edge after reset is released. After k edges, bp_o is (k / DIV_HALF) mod 2.
- R10: With INT_PHASE=1, bp_o is the phase source and phase_i has no effect on seg_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| digit_i | input | 4 | BCD digit, bit 3 is MSB |
| load_en_i | input | 1 | Stored digit follows digit_i while high |
| blank_i | input | 1 | Forces all segments off |
| phase_i | input | 1 | Inverts all segments when high (external phase) |
| seg_o | output | 7 | Segments, bit 0 = a ... bit 6 = g |
| bp_o | output | 1 | Backplane square wave |

## Verification
A wrong stored digit shows up on seg_o in the cycle right after the faulty edge. The bench checks seg_o there, under every combination of blank and phase, so a corrupted register, a missed hold or a wrong reset value cannot stay hidden for more than one cycle. A decode or inversion fault shows up at once, combinationally, at the first code that uses the faulty segment. A divider off by one shifts bp_o by at least one cycle within the first DIV_HALF edges after reset.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_N  = 7;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_N-1:0]  seg_t;

  // Per segment (index 0=a .. 6=g): bit n set when digit n lights it.
  localparam logic [9:0] SEG_DIGITS [SEG_N] = '{
    10'h3ED, 10'h39F, 10'h3FB, 10'h36D, 10'h145, 10'h371, 10'h37C
  };
endpackage

// File: rtl/code_store.sv
module code_store
  import bcd_seg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_en_i,
  input  code_t d_i,
  output code_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= '0;
    else if (load_en_i) q_o <= d_i;
  end
endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import bcd_seg_pkg::*;
(
  input  code_t code_i,
  output seg_t  seg_o
);
  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    // codes 10..15 map to zero bits -> dark
    localparam logic [15:0] LIT = {6'b0, SEG_DIGITS[s]};
    assign seg_o[s] = LIT[code_i];
  end
endmodule

// File: rtl/seg_drive.sv
module seg_drive
  import bcd_seg_pkg::*;
(
  input  seg_t seg_i,
  input  logic blank_i,
  input  logic phase_i,
  output seg_t seg_o
);
  seg_t gated;
  assign gated = blank_i ? '0 : seg_i;
  assign seg_o = gated ^ {SEG_N{phase_i}};
endmodule

// File: rtl/backplane_gen.sv
module backplane_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bp_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bp_o  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      bp_o  <= ~bp_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bcd_seg_latch_dec.sv
module bcd_seg_latch_dec
  import bcd_seg_pkg::*;
#(
  parameter int DIV_HALF  = 4,
  parameter bit INT_PHASE = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] digit_i,
  input  logic       load_en_i,
  input  logic       blank_i,
  input  logic       phase_i,
  output logic [6:0] seg_o,
  output logic       bp_o
);
  code_t code_q;
  seg_t  raw_seg;
  logic  phase_eff;

  code_store u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_en_i(load_en_i),
    .d_i      (digit_i),
    .q_o      (code_q)
  );

  seg_decode u_dec (
    .code_i(code_q),
    .seg_o (raw_seg)
  );

  backplane_gen #(.DIV_HALF(DIV_HALF)) u_bp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bp_o  (bp_o)
  );

  if (INT_PHASE) begin : g_int_phase
    assign phase_eff = bp_o;
  end else begin : g_ext_phase
    assign phase_eff = phase_i;
  end

  seg_drive u_drv (
    .seg_i  (raw_seg),
    .blank_i(blank_i),
    .phase_i(phase_eff),
    .seg_o  (seg_o)
  );
endmodule

// File: rtl/bcd_seg_latch_dec_chk.sv
module bcd_seg_latch_dec_chk #(
  parameter int DIV_HALF = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] digit_i,
  input logic       load_en_i,
  input logic       blank_i,
  input logic [3:0] code_q,
  input logic       phase_eff,
  input logic [6:0] seg_o,
  input logic       bp_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  logic [CW-1:0] ref_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ref_cnt <= '0;
    else if (ref_cnt == CW'(DIV_HALF-1))  ref_cnt <= '0;
    else                                  ref_cnt <= ref_cnt + 1'b1;
  end

  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> code_q == $past(digit_i));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_en_i |=> $stable(code_q));

  p_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> seg_o == {7{phase_eff}});

  p_zero_glyph_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_i && !phase_eff && code_q == 4'd0) |-> seg_o == 7'h3F);

  p_dark_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q > 4'd9) |-> seg_o == {7{phase_eff}});

  p_bp_toggle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_cnt == CW'(DIV_HALF-1)) |=> bp_o != $past(bp_o));

  p_bp_steady_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_cnt != CW'(DIV_HALF-1)) |=> $stable(bp_o));
endmodule

bind bcd_seg_latch_dec bcd_seg_latch_dec_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .digit_i  (digit_i),
  .load_en_i(load_en_i),
  .blank_i  (blank_i),
  .code_q   (code_q),
  .phase_eff(phase_eff),
  .seg_o    (seg_o),
  .bp_o     (bp_o)
);

// File: tb/bcd_seg_latch_dec_bench.sv
module bcd_seg_latch_dec_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] digit = '0;
  logic       load_en = 1'b0;
  logic       blank = 1'b0;
  logic       phase = 1'b0;
  logic [6:0] seg, seg_int;
  logic       bp, bp_int;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_seg_latch_dec #(.DIV_HALF(DIV), .INT_PHASE(1'b0)) u_bcd_seg_latch_dec (
    .clk_i(clk), .rst_ni(rst_n), .digit_i(digit), .load_en_i(load_en),
    .blank_i(blank), .phase_i(phase), .seg_o(seg), .bp_o(bp)
  );

  bcd_seg_latch_dec #(.DIV_HALF(DIV), .INT_PHASE(1'b1)) u_bcd_seg_latch_dec_int (
    .clk_i(clk), .rst_ni(rst_n), .digit_i(digit), .load_en_i(load_en),
    .blank_i(blank), .phase_i(phase), .seg_o(seg_int), .bp_o(bp_int)
  );

  function automatic logic [6:0] glyph(input int c);
    case (c)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] expect_seg(input int c, input bit b, input bit p);
    logic [6:0] v;
    v = b ? 7'h00 : glyph(c);
    return v ^ {7{p}};
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input int c);
    @(negedge clk);
    digit = 4'(c);
    load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    phase = 1'b1;  // R10: phase_i must not affect the internal-phase instance
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state; R9 backplane sequence; R10 internal phase
    check("R8 reset digit", seg, expect_seg(0, 0, 1));
    check("R8 reset bp", {6'b0, bp}, 7'h00);
    for (int k = 0; k <= 4 * DIV; k++) begin
      bit bexp;
      bexp = bit'((k / DIV) % 2);
      check("R9 bp", {6'b0, bp}, {6'b0, bexp});
      check("R10 int phase", seg_int, expect_seg(0, 0, bexp));
      @(negedge clk);
    end
    phase = 1'b0;

    // R4 R5 R6 R3: full sweep of codes, blank, phase
    for (int c = 0; c < 16; c++) begin
      load(c);
      for (int b = 0; b < 2; b++) begin
        for (int p = 0; p < 2; p++) begin
          blank = bit'(b);
          phase = bit'(p);
          #1;
          if (b == 1)      check("R3 blank", seg, expect_seg(c, 1, bit'(p)));
          else if (c > 9)  check("R5 dark code", seg, expect_seg(c, 0, bit'(p)));
          else if (p == 1) check("R6 inverted", seg, expect_seg(c, 0, 1));
          else             check("R4 glyph", seg, expect_seg(c, 0, 0));
        end
      end
      blank = 1'b0;
      phase = 1'b0;
    end

    // R1: update only at the edge
    load(3);
    @(negedge clk);
    digit = 4'd8;
    load_en = 1'b1;
    #1;
    check("R1 before edge", seg, glyph(3));
    @(negedge clk);
    check("R1 after edge", seg, glyph(8));
    digit = 4'd2;
    @(negedge clk);
    check("R1 follows", seg, glyph(2));
    load_en = 1'b0;

    // R2: hold across input changes
    for (int c = 0; c < 16; c++) begin
      digit = 4'(c);
      @(negedge clk);
      check("R2 hold", seg, glyph(2));
    end

    // R7: blank/phase leave stored digit intact
    load(7);
    blank = 1'b1;
    phase = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 blanked", seg, 7'h7F);
    blank = 1'b0;
    phase = 1'b0;
    #1;
    check("R7 reappears", seg, glyph(7));

    // R8: reset again clears stored digit
    load(9);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async clear", seg, glyph(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", seg, glyph(0));

    done = 1'b1;
    finish_run();
  end
endmodule